// File: doc/BRIEF.md
# Single-Input-Change Test Vector Expander

This block turns each N-bit basis pattern into a walk of 2N test vectors for path delay testing. The basis comes from an external seeded pseudo-random source; a different seed gives a different set of basis patterns and so a different fault coverage. The expander visits each input position from index 0 up to N-1. For each position it first emits the basis with that one bit inverted, then emits the basis again with the bit restored. Every input therefore receives one rising and one falling transition, and consecutive vectors in a walk differ in exactly one bit.

A run starts with a start pulse that carries the number of basis patterns to expand. The block pulls each basis over a valid/ready handshake. It fetches a new basis only after the last vector of the current one has been accepted. Vectors leave over a second valid/ready handshake and hold while the consumer stalls. When the requested number of bases has been fully expanded, a one-cycle done pulse marks the end of the run and the block goes idle.

Top module: `sic_pair_gen`

## Requirements
- R1: After synchronous reset, vec_valid, seed_ready and done are all 0.
- R2: A start pulse with a nonzero num_basis in the idle state raises seed_ready in the next cycle. The basis accepted on a seed_valid/seed_ready handshake is shown as the first vector (vec_bit = 0) in the following cycle.
- R3: For basis B, the vectors in order are: for p from 0 to N-1, first B with bit p inverted, then B unchanged. That gives 2N vectors per basis.
- R4: Within one basis, each accepted vector differs from the next one in exactly one bit.
- R5: vec_bit carries the index p of the toggled position. vec_rise is 1 exactly when bit p of the emitted vector is 1.
- R6: While vec_valid is 1 and vec_ready is 0, vec_data, vec_bit and vec_rise hold their values and vec_valid stays 1.
- R7: seed_ready and vec_valid are never 1 together. seed_ready rises in the cycle after the last vector of a basis is accepted, unless that basis was the final one. While seed_valid stays low, no vector is produced.
- R8: done is a one-cycle pulse in the cycle after the final vector of the num_basis-th basis is accepted. After it, the block is idle, with seed_ready and vec_valid both 0.
- R9: A start pulse with num_basis = 0 produces a done pulse in the next cycle and no seed fetch.
- R10: A start pulse while a run is in progress is ignored. The run keeps its original basis count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (sampled only when idle) |
| num_basis | input | CNT_W | Number of basis patterns in the run |
| seed_valid | input | 1 | Basis pattern offered by the seed source |
| seed_ready | output | 1 | Block accepts a basis pattern |
| seed_data | input | WIDTH | Basis pattern |
| vec_valid | output | 1 | Test vector available |
| vec_ready | input | 1 | Consumer accepts the test vector |
| vec_data | output | WIDTH | Test vector |
| vec_bit | output | IDX_W | Index of the toggled position |
| vec_rise | output | 1 | 1 when the toggled bit is now 1 |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench feeds all-zero, all-one and mixed bases. An expander that got the toggle polarity wrong would show a stuck-at-basis vector first or mislabel rise and fall on the uniform patterns. Some vectors are stalled, to catch a position counter that advances without a handshake. Other stalls sit between bases, to catch a block that fetches early or shows vectors before the new basis arrives. The run-length edges (zero bases, one base, and a start pulse in the middle of a run) would expose a miscounted done pulse or a run that restarts by accident.

// File: rtl/sic_pkg.sv
package sic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EMIT  = 2'd2
    } run_state_e;

    // First vector of a position flips the bit away, second brings it back.
    typedef enum logic {
        PH_AWAY = 1'b0,
        PH_BACK = 1'b1
    } phase_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sic_walker.sv
module sic_walker
    import sic_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    localparam int unsigned IDX_W = idx_width(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance,
    output logic [IDX_W-1:0] pos,
    output phase_e           phase,
    output logic             last
);

    localparam logic [IDX_W-1:0] TOP_POS = IDX_W'(WIDTH - 1);

    assign last = (phase == PH_BACK) && (pos == TOP_POS);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pos   <= '0;
            phase <= PH_AWAY;
        end else if (advance) begin
            if (phase == PH_AWAY) begin
                phase <= PH_BACK;
            end else begin
                phase <= PH_AWAY;
                pos   <= last ? '0 : pos + 1'b1;
            end
        end
    end

    // R3: the position index never runs past the top input
    a_r3_pos_in_range: assert property (@(posedge clk) disable iff (rst)
        pos <= TOP_POS);

endmodule

// File: rtl/sic_former.sv
module sic_former
    import sic_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    localparam int unsigned IDX_W = idx_width(WIDTH)
) (
    input  logic [WIDTH-1:0] basis,
    input  logic [IDX_W-1:0] pos,
    input  phase_e           phase,
    output logic [WIDTH-1:0] data,
    output logic             rise
);

    logic [WIDTH-1:0] flip_mask;

    for (genvar i = 0; i < WIDTH; i++) begin : g_mask
        assign flip_mask[i] = (phase == PH_AWAY) && (pos == IDX_W'(i));
    end

    assign data = basis ^ flip_mask;

    always_comb begin
        rise = basis[pos];
        if (phase == PH_AWAY) begin
            rise = ~basis[pos];
        end
    end

endmodule

// File: rtl/sic_ctrl.sv
module sic_ctrl
    import sic_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] num_basis,
    input  logic             seed_valid,
    input  logic             last_fire,
    output run_state_e       state,
    output logic             seed_ready,
    output logic             load,
    output logic             emitting,
    output logic             done
);

    logic [CNT_W-1:0] target;
    logic [CNT_W-1:0] served;
    logic             final_basis;

    assign seed_ready  = (state == ST_FETCH);
    assign load        = seed_ready && seed_valid;
    assign emitting    = (state == ST_EMIT);
    assign final_basis = (served == target - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            target <= '0;
            served <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (num_basis == '0) begin
                            done <= 1'b1;
                        end else begin
                            target <= num_basis;
                            served <= '0;
                            state  <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: begin
                    if (seed_valid) begin
                        state <= ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    if (last_fire) begin
                        if (final_basis) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            served <= served + 1'b1;
                            state  <= ST_FETCH;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8: done never lasts longer than one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: the end-of-run pulse leaves the block idle
    a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> state == ST_IDLE);

endmodule

// File: rtl/sic_pair_gen.sv
module sic_pair_gen
    import sic_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned CNT_W = 8,
    localparam int unsigned IDX_W = idx_width(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] num_basis,
    input  logic             seed_valid,
    output logic             seed_ready,
    input  logic [WIDTH-1:0] seed_data,
    output logic             vec_valid,
    input  logic             vec_ready,
    output logic [WIDTH-1:0] vec_data,
    output logic [IDX_W-1:0] vec_bit,
    output logic             vec_rise,
    output logic             done
);

    run_state_e       state;
    logic             load;
    logic             emitting;
    logic             vec_fire;
    logic             last;
    logic [IDX_W-1:0] pos;
    phase_e           phase;
    logic [WIDTH-1:0] basis;

    assign vec_valid = emitting;
    assign vec_fire  = vec_valid && vec_ready;
    assign vec_bit   = pos;

    always_ff @(posedge clk) begin
        if (rst) begin
            basis <= '0;
        end else if (load) begin
            basis <= seed_data;
        end
    end

    sic_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .num_basis  (num_basis),
        .seed_valid (seed_valid),
        .last_fire  (vec_fire && last),
        .state      (state),
        .seed_ready (seed_ready),
        .load       (load),
        .emitting   (emitting),
        .done       (done)
    );

    sic_walker #(.WIDTH(WIDTH)) u_walker (
        .clk     (clk),
        .rst     (rst),
        .clear   (load),
        .advance (vec_fire),
        .pos     (pos),
        .phase   (phase),
        .last    (last)
    );

    sic_former #(.WIDTH(WIDTH)) u_former (
        .basis (basis),
        .pos   (pos),
        .phase (phase),
        .data  (vec_data),
        .rise  (vec_rise)
    );

    // R4: neighbouring vectors of one basis differ in a single bit
    a_r4_one_bit_step: assert property (@(posedge clk) disable iff (rst)
        (vec_fire && !last) |=> $countones(vec_data ^ $past(vec_data)) == 1);

    // R5: the return vector carries the opposite edge of the away vector
    a_r5_edge_pairs: assert property (@(posedge clk) disable iff (rst)
        (vec_fire && phase == PH_AWAY) |=> vec_rise != $past(vec_rise));

    // R6: a stalled vector holds still
    a_r6_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && !vec_ready) |=> vec_valid && $stable(vec_data)
            && $stable(vec_bit) && $stable(vec_rise));

    // R7: fetch and emit never overlap
    a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(seed_ready && vec_valid));

    // R2: a new basis starts its walk at position 0
    a_r2_walk_start: assert property (@(posedge clk) disable iff (rst)
        load |=> vec_valid && vec_bit == '0);

endmodule

// File: tb/tb_sic_pair_gen.sv
module tb_sic_pair_gen;

    localparam int W   = 8;
    localparam int CW  = 8;
    localparam int IW  = 3;
    localparam int NB  = 4;

    // {stall flag, basis}
    localparam logic [8:0] TABLE [NB] = '{9'h0_00, 9'h1_FF, 9'h0_A5, 9'h1_3C};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [CW-1:0] num_basis = '0;
    logic          seed_valid = 1'b0;
    logic          seed_ready;
    logic [W-1:0]  seed_data = '0;
    logic          vec_valid;
    logic          vec_ready = 1'b0;
    logic [W-1:0]  vec_data;
    logic [IW-1:0] vec_bit;
    logic          vec_rise;
    logic          done;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #5 clk = ~clk;

    sic_pair_gen #(.WIDTH(W), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .start(start), .num_basis(num_basis),
        .seed_valid(seed_valid), .seed_ready(seed_ready), .seed_data(seed_data),
        .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_data(vec_data),
        .vec_bit(vec_bit), .vec_rise(vec_rise), .done(done)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Offer one basis; returns at the negedge after the handshake.
    task automatic feed(input logic [W-1:0] b);
        seed_valid = 1'b1;
        seed_data  = b;
        @(negedge clk);
        seed_valid = 1'b0;
        chk(vec_valid === 1'b1, "R2 vec_valid after load", vec_valid, 1);
        chk(vec_bit === '0, "R2 walk starts at bit 0", vec_bit, 0);
    endtask

    // Accept all 2N vectors of basis b; returns at negedge after the last.
    task automatic drain(input logic [W-1:0] b, input bit stall);
        for (int p = 0; p < W; p++) begin
            for (int ph = 0; ph < 2; ph++) begin
                logic [W-1:0] exp_v;
                exp_v = (ph == 0) ? (b ^ (W'(1) << p)) : b;
                if (stall) begin
                    vec_ready = 1'b0;
                    @(negedge clk);
                    chk(vec_valid === 1'b1, "R6 valid held in stall", vec_valid, 1);
                end
                chk(vec_data === exp_v, "R3 vector value", vec_data, exp_v);
                chk(vec_bit === IW'(p), "R5 toggled index", vec_bit, p);
                chk(vec_rise === exp_v[p], "R5 rise flag", vec_rise, exp_v[p]);
                chk(seed_ready === 1'b0, "R7 no fetch mid-walk", seed_ready, 0);
                vec_ready = 1'b1;
                @(negedge clk);
                vec_ready = 1'b0;
            end
        end
    endtask

    initial begin
        // Reset
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(vec_valid === 1'b0, "R1 vec_valid reset", vec_valid, 0);
        chk(seed_ready === 1'b0, "R1 seed_ready reset", seed_ready, 0);
        chk(done === 1'b0, "R1 done reset", done, 0);

        // Table-driven run of NB bases
        num_basis = CW'(NB);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(seed_ready === 1'b1, "R2 seed_ready after start", seed_ready, 1);
        for (int k = 0; k < NB; k++) begin
            if (k == 1) begin
                repeat (3) begin
                    @(negedge clk);
                    chk(vec_valid === 1'b0, "R7 no vector without seed", vec_valid, 0);
                    chk(seed_ready === 1'b1, "R7 waiting for seed", seed_ready, 1);
                end
            end
            feed(TABLE[k][W-1:0]);
            drain(TABLE[k][W-1:0], TABLE[k][8]);
            if (k < NB - 1) begin
                chk(seed_ready === 1'b1, "R7 fetch after last vector", seed_ready, 1);
                chk(done === 1'b0, "R8 no early done", done, 0);
            end else begin
                chk(done === 1'b1, "R8 done after final basis", done, 1);
            end
        end
        @(negedge clk);
        chk(done === 1'b0, "R8 done one cycle", done, 0);
        chk(seed_ready === 1'b0, "R8 idle no fetch", seed_ready, 0);
        chk(vec_valid === 1'b0, "R8 idle no vector", vec_valid, 0);

        // Zero-length run
        num_basis = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done === 1'b1, "R9 done on empty run", done, 1);
        chk(seed_ready === 1'b0, "R9 no fetch on empty run", seed_ready, 0);
        @(negedge clk);
        chk(done === 1'b0, "R9 single pulse", done, 0);

        // Start pulse in the middle of a run is ignored
        num_basis = 8'd1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        feed(8'h81);
        num_basis = 8'd5;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        drain(8'h81, 1'b0);
        chk(done === 1'b1, "R10 run keeps original count", done, 1);
        repeat (3) begin
            @(negedge clk);
            chk(seed_ready === 1'b0, "R10 no restart", seed_ready, 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule